// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data on a common clock between a 12-bit narrow port (A) and a 24-bit wide port (B). The wide port is treated as two 12-bit halves: the low half (bits 11:0, called 1B) and the high half (bits 23:12, called 2B). In the narrow-to-wide direction, the low-half path holds two register stages and the high-half path holds one. With the clock enables driven correctly, two narrow words that arrive one after the other therefore leave together as one wide word.

In the wide-to-narrow direction, each half of B is captured into its own register, and each register has its own clock enable. A registered select then chooses which stored half drives A. Tri-state ports are modelled as a data vector plus a drive flag. The drive flags come from registered active-low output enables, so the bus direction changes only on a clock edge. An active-low asynchronous reset clears every register and leaves both ports undriven.

Top module: `nw_bus_exchanger`

## Requirements
- R1: While `rst_ni` is low, and after it is released until an enable is taken, `a_drv_o` and `b_drv_o` are 0. All stored data is zero, and the select points at the low half (1B).
- R2: On a rising edge with `a2_ce_ni` low, `b_o[23:12]` takes the value of `a_i`.
- R3: On a rising edge with `a1_ce_ni` low, the first low-half stage captures `a_i`. On a rising edge with `a2_ce_ni` low, `b_o[11:0]` takes the value that the first stage held before that edge.
- R4: Word W0 is captured with `a1_ce_ni`=0 and `a2_ce_ni`=1. On the next edge, word W1 is applied with `a1_ce_ni`=1 and `a2_ce_ni`=0. After that edge, `b_o` reads {W1, W0}, with W0 in bits 11:0.
- R5: While a clock enable is high, its register holds. With `a2_ce_ni` high, `b_o` does not change whatever `a_i` does.
- R6: On a rising edge with `b1_ce_ni` low, the low-half capture register takes `b_i[11:0]`. With `b2_ce_ni` low, the high-half capture register takes `b_i[23:12]`.
- R7: `sel_ni` is sampled on the rising edge. A sampled 0 drives the stored low half (1B) onto `a_o`, and a sampled 1 drives the stored high half (2B). A change shows only after the next edge.
- R8: `oe_a_ni` and `oe_b_ni` are active low and sampled on the rising edge. `a_drv_o` and `b_drv_o` equal the inverse of the last sampled value, so a change shows only after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 12 | Narrow port input data |
| a1_ce_ni | input | 1 | Clock enable for the first low-half stage, active low |
| a2_ce_ni | input | 1 | Clock enable for the wide output registers, active low |
| b_i | input | 24 | Wide port input data (11:0 = 1B, 23:12 = 2B) |
| b1_ce_ni | input | 1 | Clock enable for the 1B capture register, active low |
| b2_ce_ni | input | 1 | Clock enable for the 2B capture register, active low |
| sel_ni | input | 1 | Source select for A (0 = 1B, 1 = 2B) |
| oe_a_ni | input | 1 | Output enable for A, active low |
| oe_b_ni | input | 1 | Output enable for B, active low |
| a_o | output | 12 | Narrow port output data |
| a_drv_o | output | 1 | A port driven flag |
| b_o | output | 24 | Wide port output data |
| b_drv_o | output | 1 | B port driven flag |

## Verification
The assertions check on every cycle the one-edge latency of the drive flags and the capture into the high half. They also check the two-edge latency into the low half, the hold of B while its enable is high, and the value routed onto A for each sampled select. Only the bench scenarios show that a specific pair of words lands together on B as {W1, W0}. The same holds for a select or enable change staying invisible before its edge, and for the undriven ports reading high impedance.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic {
    SRC_1B = 1'b0,
    SRC_2B = 1'b1
  } src_e;
endpackage

// File: rtl/xchg_ce_reg.sv
module xchg_ce_reg #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (!ce_ni) q_o <= d_i;
  end
endmodule

// File: rtl/xchg_a2b.sv
module xchg_a2b #(
  parameter int WORD_W = 12,
  localparam int WIDE_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] a_i,
  input  logic              s1_ce_ni,
  input  logic              wide_ce_ni,
  output logic [WIDE_W-1:0] b_o
);
  logic [WORD_W-1:0] s1_q;

  // low half gets an extra stage so word N-1 pairs with word N
  xchg_ce_reg #(.W(WORD_W)) u_s1 (
    .clk_i, .rst_ni, .ce_ni(s1_ce_ni), .d_i(a_i), .q_o(s1_q)
  );
  xchg_ce_reg #(.W(WORD_W)) u_lo (
    .clk_i, .rst_ni, .ce_ni(wide_ce_ni), .d_i(s1_q), .q_o(b_o[WORD_W-1:0])
  );
  xchg_ce_reg #(.W(WORD_W)) u_hi (
    .clk_i, .rst_ni, .ce_ni(wide_ce_ni), .d_i(a_i), .q_o(b_o[WIDE_W-1:WORD_W])
  );
endmodule

// File: rtl/xchg_b2a.sv
module xchg_b2a
  import xchg_pkg::*;
#(
  parameter int WORD_W = 12,
  localparam int NHALF = 2,
  localparam int WIDE_W = NHALF * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDE_W-1:0] b_i,
  input  logic [NHALF-1:0]  ce_ni,
  input  src_e              sel_i,
  output logic [WORD_W-1:0] a_o
);
  logic [WORD_W-1:0] half_q [NHALF];

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    xchg_ce_reg #(.W(WORD_W)) u_cap (
      .clk_i, .rst_ni, .ce_ni(ce_ni[g]), .d_i(b_i[g*WORD_W +: WORD_W]), .q_o(half_q[g])
    );
  end

  assign a_o = (sel_i == SRC_2B) ? half_q[1] : half_q[0];
endmodule

// File: rtl/xchg_ctl.sv
module xchg_ctl
  import xchg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic oe_a_ni,
  input  logic oe_b_ni,
  output src_e sel_o,
  output logic a_drv_o,
  output logic b_drv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= SRC_1B;
      a_drv_o <= 1'b0;
      b_drv_o <= 1'b0;
    end else begin
      sel_o   <= sel_ni ? SRC_2B : SRC_1B;
      a_drv_o <= ~oe_a_ni;
      b_drv_o <= ~oe_b_ni;
    end
  end
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
  import xchg_pkg::*;
#(
  parameter int WORD_W = 12,
  localparam int WIDE_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] a_i,
  input  logic              a1_ce_ni,
  input  logic              a2_ce_ni,
  input  logic [WIDE_W-1:0] b_i,
  input  logic              b1_ce_ni,
  input  logic              b2_ce_ni,
  input  logic              sel_ni,
  input  logic              oe_a_ni,
  input  logic              oe_b_ni,
  output logic [WORD_W-1:0] a_o,
  output logic              a_drv_o,
  output logic [WIDE_W-1:0] b_o,
  output logic              b_drv_o
);
  src_e sel_q;

  xchg_ctl u_ctl (
    .clk_i, .rst_ni, .sel_ni, .oe_a_ni, .oe_b_ni,
    .sel_o(sel_q), .a_drv_o, .b_drv_o
  );

  xchg_a2b #(.WORD_W(WORD_W)) u_a2b (
    .clk_i, .rst_ni, .a_i, .s1_ce_ni(a1_ce_ni), .wide_ce_ni(a2_ce_ni), .b_o
  );

  xchg_b2a #(.WORD_W(WORD_W)) u_b2a (
    .clk_i, .rst_ni, .b_i, .ce_ni({b2_ce_ni, b1_ce_ni}), .sel_i(sel_q), .a_o
  );
endmodule

// File: rtl/nw_bus_exchanger_chk.sv
module nw_bus_exchanger_chk #(
  parameter int WORD_W = 12,
  localparam int WIDE_W = 2 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] a_i,
  input logic              a1_ce_ni,
  input logic              a2_ce_ni,
  input logic [WIDE_W-1:0] b_i,
  input logic              b1_ce_ni,
  input logic              b2_ce_ni,
  input logic              sel_ni,
  input logic              oe_a_ni,
  input logic              oe_b_ni,
  input logic [WORD_W-1:0] a_o,
  input logic              a_drv_o,
  input logic [WIDE_W-1:0] b_o,
  input logic              b_drv_o
);
  logic [1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= '0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  assert_hi_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) && !$past(a2_ce_ni) |-> b_o[WIDE_W-1:WORD_W] == $past(a_i));

  assert_lo_two_stage_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == 2'd2) && !$past(a2_ce_ni) && !$past(a1_ce_ni, 2) |-> b_o[WORD_W-1:0] == $past(a_i, 2));

  assert_b_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) && $past(a2_ce_ni) |-> $stable(b_o));

  assert_a_from_1b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) && !$past(sel_ni) && !$past(b1_ce_ni) |-> a_o == $past(b_i[WORD_W-1:0]));

  assert_a_from_2b_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) && $past(sel_ni) && !$past(b2_ce_ni) |-> a_o == $past(b_i[WIDE_W-1:WORD_W]));

  assert_a_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) |-> a_drv_o == !$past(oe_a_ni));

  assert_b_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q != 2'd0) |-> b_drv_o == !$past(oe_b_ni));

  always_comb begin
    if (!rst_ni) assert_reset_undriven_R1: assert (!a_drv_o && !b_drv_o);
  end
endmodule

bind nw_bus_exchanger nw_bus_exchanger_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/nw_bus_exchanger_bench.sv
`timescale 1ns/1ps
module nw_bus_exchanger_bench;
  localparam int W  = 12;
  localparam int WW = 2 * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [WW-1:0] b_i = '0;
  logic a1_ce_ni = 1'b1, a2_ce_ni = 1'b1, b1_ce_ni = 1'b1, b2_ce_ni = 1'b1;
  logic sel_ni = 1'b0, oe_a_ni = 1'b1, oe_b_ni = 1'b1;
  logic [W-1:0]  a_o;
  logic [WW-1:0] b_o;
  logic a_drv_o, b_drv_o;
  wire  [W-1:0]  a_bus = a_drv_o ? a_o : 'z;
  wire  [WW-1:0] b_bus = b_drv_o ? b_o : 'z;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  int m_s1, m_lo, m_hi, m_c1, m_c2;
  bit m_sel, m_da, m_db;

  always #2.5 clk = ~clk;

  nw_bus_exchanger u_nw_bus_exchanger (
    .clk_i(clk), .rst_ni, .a_i, .a1_ce_ni, .a2_ce_ni, .b_i, .b1_ce_ni, .b2_ce_ni,
    .sel_ni, .oe_a_ni, .oe_b_ni, .a_o, .a_drv_o, .b_o, .b_drv_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    int new_lo, new_hi, new_s1;
    @(posedge clk);
    if (!rst_ni) begin
      m_s1 = 0; m_lo = 0; m_hi = 0; m_c1 = 0; m_c2 = 0;
      m_sel = 0; m_da = 0; m_db = 0;
    end else begin
      new_lo = a2_ce_ni ? m_lo : m_s1;
      new_hi = a2_ce_ni ? m_hi : int'(a_i);
      new_s1 = a1_ce_ni ? m_s1 : int'(a_i);
      m_lo = new_lo; m_hi = new_hi; m_s1 = new_s1;
      if (!b1_ce_ni) m_c1 = int'(b_i[W-1:0]);
      if (!b2_ce_ni) m_c2 = int'(b_i[WW-1:W]);
      m_sel = sel_ni;
      m_da  = !oe_a_ni;
      m_db  = !oe_b_ni;
    end
    @(negedge clk);
    chk("R8 a_drv", 32'(a_drv_o), 32'(m_da));
    chk("R8 b_drv", 32'(b_drv_o), 32'(m_db));
    chk("R2 b_hi",  32'(b_o[WW-1:W]), 32'(m_hi));
    chk("R3 b_lo",  32'(b_o[W-1:0]), 32'(m_lo));
    chk("R6/R7 a_o", 32'(a_o), 32'(m_sel ? m_c2 : m_c1));
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [WW-1:0] held;
    repeat (3) step();
    // R1: state under reset, after edges have occurred
    chk("R1 a_drv", 32'(a_drv_o), 0);
    chk("R1 b_drv", 32'(b_drv_o), 0);
    chk("R1 b_o", 32'(b_o), 0);
    chk("R1 a_o", 32'(a_o), 0);
    chk("R1 a_bus z", 32'(a_bus === 'z), 1);
    rst_ni = 1'b1;
    step();
    chk("R1 undriven after release", 32'({a_drv_o, b_drv_o}), 0);

    // R4: pair two narrow words on the wide port
    a_i = 12'hA5C; a1_ce_ni = 1'b0; a2_ce_ni = 1'b1;
    step();
    a_i = 12'h3B7; a1_ce_ni = 1'b1; a2_ce_ni = 1'b0;
    step();
    chk("R4 pair", 32'(b_o), 32'({12'h3B7, 12'hA5C}));
    a2_ce_ni = 1'b1;

    // R5: hold while enables high
    held = b_o;
    for (int i = 0; i < 4; i++) begin
      a_i = 12'(i * 12'h155 + 12'h0F1);
      step();
    end
    chk("R5 b_o held", 32'(b_o), 32'(held));

    // R8: enable change shows only after the edge
    oe_b_ni = 1'b0;
    #1 chk("R8 b_drv before edge", 32'(b_drv_o), 0);
    step();
    chk("R8 b_drv after edge", 32'(b_drv_o), 1);
    chk("R8 b_bus driven", 32'(b_bus), 32'(held));

    // R6/R7: capture halves, select with one-edge delay
    b_i = {12'h222, 12'h111}; b1_ce_ni = 1'b0; b2_ce_ni = 1'b0; oe_a_ni = 1'b0;
    step();
    b1_ce_ni = 1'b1; b2_ce_ni = 1'b1;
    chk("R6/R7 a_o from 1B", 32'(a_o), 32'h111);
    sel_ni = 1'b1;
    #1 chk("R7 sel before edge", 32'(a_o), 32'h111);
    step();
    chk("R7 a_o from 2B", 32'(a_o), 32'h222);
    chk("R8 a_bus driven", 32'(a_bus), 32'h222);

    // mixed stimulus against the model
    for (int i = 0; i < 400; i++) begin
      a_i      = 12'($urandom);
      b_i      = 24'($urandom);
      a1_ce_ni = 1'($urandom_range(0, 1));
      a2_ce_ni = 1'($urandom_range(0, 1));
      b1_ce_ni = 1'($urandom_range(0, 1));
      b2_ce_ni = 1'($urandom_range(0, 1));
      sel_ni   = 1'($urandom_range(0, 1));
      oe_a_ni  = 1'($urandom_range(0, 1));
      oe_b_ni  = 1'($urandom_range(0, 1));
      step();
    end
    finish_run();
  end
endmodule